// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block connects a load/store pipeline to a memory built from fixed-width rows. A request carries a byte address, a size code (1, 2, 4 or 8 bytes), a per-access byte-reverse flag and, for writes, the write data. The block turns the address into a row index plus a byte offset, derives a bit shift and a lane mask from that offset, and uses them to pull a narrow value out of a row on loads or to fold a narrow value into a row on stores (read-modify-write).

The memory is expected to have a synchronous read port: the row index and read enable are presented in the request cycle, and the row word returns in the next cycle. In that next cycle a load presents its zero-extended result, and a store presents the merged row on the write port. A store followed at once by another access to the same row is covered by an internal forward of the row just written, so requests may be issued every cycle. An address whose offset is not a multiple of the access size is not performed. Instead the error output is raised and memory is left as it was.

Top module: `lsa_lane_aligner`

## Requirements
- R1: For an aligned request, `mem_rd_en` is high in the request cycle and `mem_rd_row` equals the address shifted right by log2(ROW_BYTES).
- R2: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. An aligned load without swap returns on `rsp_data` the bytes at addr..addr+w-1, with the lowest address in bits 7:0, zero-extended to 64 bits. `rsp_valid` is high for exactly the one cycle after the request. Rows never written read as zero.
- R3: A load with `req_swap` set returns the same w bytes in reversed order: the lowest address is in the most significant of the w bytes. Bits above w bytes stay zero.
- R4: An aligned store writes back the addressed row one cycle after the request. Only the w addressed bytes change, they come from the low w bytes of `req_wdata`, and the higher bits of `req_wdata` are ignored. A store never raises `rsp_valid`.
- R5: A store with `req_swap` set places the most significant of the w low data bytes at the lowest address.
- R6: When the offset is not a multiple of w, `rsp_err` is high one cycle after the request, no row is written, and for a load `rsp_valid` is high with `rsp_data` zero.
- R7: An 8-byte access at offset 0 of an 8-byte row moves the whole row with no masking or shifting.
- R8: An access issued in the cycle right after a store to the same row observes the data of that store.
- R9: While `rst_n` is low and in the first cycle after it, `rsp_valid`, `rsp_err` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (log2 of byte count) |
| req_swap | input | 1 | Reverse the bytes of this access |
| req_wdata | input | 64 | Store data, low bytes used |
| mem_rd_en | output | 1 | Row read strobe |
| mem_rd_row | output | ADDR_W-log2(ROW_BYTES) | Row to read |
| mem_rd_data | input | ROW_BYTES*8 | Row word, one cycle after the read |
| mem_wr_en | output | 1 | Row write strobe |
| mem_wr_row | output | ADDR_W-log2(ROW_BYTES) | Row to write |
| mem_wr_data | output | ROW_BYTES*8 | Merged row word |
| rsp_valid | output | 1 | Load result present |
| rsp_err | output | 1 | Misaligned request rejected |
| rsp_data | output | 64 | Load result, zero-extended |

## Verification
The bench builds the block with ADDR_W=12 and ROW_BYTES=8, so an 8-byte access is the full-row case and the 512-row memory stays small. Random traffic is confined to the first eight rows. This makes store-then-access pairs to the same row in consecutive cycles frequent, which exercises the forwarding path. Every size and offset pairing, aligned and misaligned, is reachable with and without swap.

// File: rtl/lsa_pkg.sv
// Shared types for the lane aligner.
// Assumes size codes are the log2 of the access byte count.
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } lsa_size_e;

    // Control carried from the request cycle to the data cycle.
    typedef struct packed {
        logic      store;
        logic      err;
        logic      swap;
        lsa_size_e size;
    } lsa_ctl_t;

endpackage

// File: rtl/lsa_addr_decode.sv
// Splits a byte address into row index and lane position, builds the lane
// mask and flags offsets that are not a multiple of the access size.
// Assumes ROW_BYTES is a power of two and at least 8.
module lsa_addr_decode #(
    parameter int ADDR_W    = 12,
    parameter int ROW_BYTES = 8,
    localparam int ROW_W    = ROW_BYTES * 8,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int IDX_W    = ADDR_W - OFF_W,
    localparam int SHIFT_W  = OFF_W + 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    output logic [IDX_W-1:0]   row,
    output logic [SHIFT_W-1:0] shift,
    output logic [ROW_W-1:0]   mask,
    output logic               misalign
);

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] low_bits;

    // Row index and byte offset come straight from the address.
    assign row   = addr[ADDR_W-1:OFF_W];
    assign off   = addr[OFF_W-1:0];
    assign shift = {off, 3'b000};

    // Offset bits that must be zero for the given size.
    always_comb begin
        low_bits = OFF_W'((1 << size) - 1);
        misalign = (off & low_bits) != '0;
    end

    // Lane mask: ones from the shift up to shift plus the access width.
    always_comb begin
        for (int b = 0; b < ROW_W; b++) begin
            mask[b] = (b >= int'(shift)) && (b < int'(shift) + (8 << size));
        end
    end

endmodule

// File: rtl/lsa_byte_swap.sv
// Keeps the low 2**size bytes of a word, optionally in reversed order,
// and clears every byte above them.
// Assumes BYTES is a power of two; sizes wider than BYTES give zero.
module lsa_byte_swap #(
    parameter int BYTES = 8,
    parameter int SZ_W  = 2,
    localparam int DW   = BYTES * 8,
    localparam int NSZ  = 1 << SZ_W
) (
    input  logic [DW-1:0]   din,
    input  logic [SZ_W-1:0] size,
    input  logic            swap,
    output logic [DW-1:0]   dout
);

    wire [NSZ-1:0][DW-1:0] cand;

    // One candidate word per size code, picked by the size below.
    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int NB = 1 << s;
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            if (NB <= BYTES && b < NB) begin : g_live
                assign cand[s][b*8 +: 8] = swap ? din[(NB-1-b)*8 +: 8] : din[b*8 +: 8];
            end else begin : g_zero
                assign cand[s][b*8 +: 8] = 8'h00;
            end
        end
    end

    // Select the candidate for this access size.
    assign dout = cand[size];

endmodule

// File: rtl/lsa_lane_merge.sv
// Lane datapath: extracts the addressed lane from a row and inserts new
// lane data into that row under the mask.
// Assumes ROW_W >= DATA_W and wdata already cleared above the lane width.
module lsa_lane_merge #(
    parameter int ROW_W   = 64,
    parameter int SHIFT_W = 6,
    parameter int DATA_W  = 64
) (
    input  logic [ROW_W-1:0]   row_in,
    input  logic [ROW_W-1:0]   mask,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [DATA_W-1:0]  wdata,
    output logic [ROW_W-1:0]   row_out,
    output logic [DATA_W-1:0]  rdata
);

    logic [ROW_W-1:0] placed;
    logic [ROW_W-1:0] picked;

    // Move store data into its lane and combine with the untouched bytes.
    always_comb begin
        placed  = ROW_W'(wdata) << shift;
        row_out = (row_in & ~mask) | (placed & mask);
    end

    // Isolate the lane and bring it down to bit 0.
    always_comb begin
        picked = (row_in & mask) >> shift;
        rdata  = picked[DATA_W-1:0];
    end

endmodule

// File: rtl/lsa_lane_aligner.sv
// Lane aligner between a load/store pipeline and a row-wide memory with a
// one-cycle synchronous read. Request cycle: decode and issue the row read.
// Next cycle: extract (load) or merge and write back (store). A row written
// in one cycle is forwarded to an access to the same row issued in that
// same cycle, because the memory returns the old row for it.
// Assumes ROW_BYTES is a power of two, at least 8; accesses up to 8 bytes.
module lsa_lane_aligner
    import lsa_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ROW_BYTES = 8,
    localparam int ROW_W    = ROW_BYTES * 8,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int IDX_W    = ADDR_W - OFF_W,
    localparam int SHIFT_W  = OFF_W + 3,
    localparam int DATA_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_rd_row,
    input  logic [ROW_W-1:0]  mem_rd_data,
    output logic              mem_wr_en,
    output logic [IDX_W-1:0]  mem_wr_row,
    output logic [ROW_W-1:0]  mem_wr_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);

    logic [IDX_W-1:0]   dec_row;
    logic [SHIFT_W-1:0] dec_shift;
    logic [ROW_W-1:0]   dec_mask;
    logic               dec_misalign;
    logic [DATA_W-1:0]  st_data;

    logic               s1_valid;
    lsa_ctl_t           s1_ctl;
    logic [IDX_W-1:0]   s1_row;
    logic [SHIFT_W-1:0] s1_shift;
    logic [ROW_W-1:0]   s1_mask;
    logic [DATA_W-1:0]  s1_wdata;
    logic               s1_fwd_hit;
    logic [ROW_W-1:0]   s1_fwd_data;

    logic [ROW_W-1:0]   row_eff;
    logic [DATA_W-1:0]  lane_rdata;
    logic [DATA_W-1:0]  ld_data;

    lsa_addr_decode #(
        .ADDR_W    (ADDR_W),
        .ROW_BYTES (ROW_BYTES)
    ) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .row      (dec_row),
        .shift    (dec_shift),
        .mask     (dec_mask),
        .misalign (dec_misalign)
    );

    // Store data is trimmed and optionally reversed in the request cycle.
    lsa_byte_swap #(
        .BYTES (DATA_W / 8),
        .SZ_W  (2)
    ) u_st_swap (
        .din  (req_wdata),
        .size (req_size),
        .swap (req_swap),
        .dout (st_data)
    );

    // Issue the row read for every aligned request.
    always_comb begin
        mem_rd_en  = req_valid & ~dec_misalign;
        mem_rd_row = dec_row;
    end

    // Pipeline valid and forward-hit flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_fwd_hit <= 1'b0;
        end else begin
            s1_valid   <= req_valid;
            s1_fwd_hit <= req_valid & mem_wr_en & (mem_wr_row == dec_row);
        end
    end

    // Request payload, only meaningful while s1_valid is set.
    always_ff @(posedge clk) begin
        s1_ctl      <= '{store: req_store, err: dec_misalign,
                         swap: req_swap, size: lsa_size_e'(req_size)};
        s1_row      <= dec_row;
        s1_shift    <= dec_shift;
        s1_mask     <= dec_mask;
        s1_wdata    <= st_data;
        s1_fwd_data <= mem_wr_data;
    end

    // Row seen by the data cycle: the just-written row wins over memory.
    assign row_eff = s1_fwd_hit ? s1_fwd_data : mem_rd_data;

    lsa_lane_merge #(
        .ROW_W   (ROW_W),
        .SHIFT_W (SHIFT_W),
        .DATA_W  (DATA_W)
    ) u_merge (
        .row_in  (row_eff),
        .mask    (s1_mask),
        .shift   (s1_shift),
        .wdata   (s1_wdata),
        .row_out (mem_wr_data),
        .rdata   (lane_rdata)
    );

    // Load data is reversed after extraction when requested.
    lsa_byte_swap #(
        .BYTES (DATA_W / 8),
        .SZ_W  (2)
    ) u_ld_swap (
        .din  (lane_rdata),
        .size (s1_ctl.size),
        .swap (s1_ctl.swap),
        .dout (ld_data)
    );

    // Write port and response outputs of the data cycle.
    always_comb begin
        mem_wr_en  = s1_valid & s1_ctl.store & ~s1_ctl.err;
        mem_wr_row = s1_row;
        rsp_valid  = s1_valid & ~s1_ctl.store;
        rsp_err    = s1_valid & s1_ctl.err;
        rsp_data   = s1_ctl.err ? '0 : ld_data;
    end

    // A load request yields a response in the next cycle.
    p_load_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |=> rsp_valid);

    // A store request never yields a load response.
    p_store_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store |=> !rsp_valid);

    // Bytes outside the lane are written back exactly as read.
    p_merge_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_wr_data ^ row_eff) & ~s1_mask) == '0);

    // An aligned store writes the row named by its address.
    p_write_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store && !dec_misalign
        |=> mem_wr_en && mem_wr_row == $past(req_addr[ADDR_W-1:OFF_W]));

    // A misaligned request is rejected and never writes.
    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dec_misalign |=> rsp_err && !mem_wr_en);

endmodule

// File: tb/lsa_lane_aligner_tb.sv
`timescale 1ns/1ps
module lsa_lane_aligner_tb;

    localparam int ADDR_W    = 12;
    localparam int ROW_BYTES = 8;
    localparam int IDX_W     = ADDR_W - 3;
    localparam int NROWS     = 1 << IDX_W;
    localparam int NBYTES    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_store = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_swap = 1'b0;
    logic [63:0]       req_wdata = '0;
    logic              mem_rd_en;
    logic [IDX_W-1:0]  mem_rd_row;
    logic [63:0]       mem_rd_data;
    logic              mem_wr_en;
    logic [IDX_W-1:0]  mem_wr_row;
    logic [63:0]       mem_wr_data;
    logic              rsp_valid;
    logic              rsp_err;
    logic [63:0]       rsp_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lsa_lane_aligner #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
        .req_wdata(req_wdata), .mem_rd_en(mem_rd_en), .mem_rd_row(mem_rd_row),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_row(mem_wr_row),
        .mem_wr_data(mem_wr_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data)
    );

    // Row memory with synchronous read (old data on a same-edge write).
    logic [63:0] mem [NROWS];
    initial for (int i = 0; i < NROWS; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_row];
        if (mem_wr_en) mem[mem_wr_row] <= mem_wr_data;
    end

    // Behavioural byte-addressed reference.
    logic [7:0] ref_mem [NBYTES];
    initial for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'h00;

    // Expectations for the cycle after the last request.
    bit          p_rv, p_err, p_we;
    logic [63:0] p_data, p_rowdata;
    int          p_row;
    string       p_tag = "R9";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_pending();
        chk(rsp_valid === p_rv, p_tag, "rsp_valid", 64'(rsp_valid), 64'(p_rv));
        chk(rsp_err === p_err, p_tag, "rsp_err", 64'(rsp_err), 64'(p_err));
        chk(mem_wr_en === p_we, p_tag, "mem_wr_en", 64'(mem_wr_en), 64'(p_we));
        if (p_rv) chk(rsp_data === p_data, p_tag, "rsp_data", rsp_data, p_data);
        if (p_we) begin
            chk(mem_wr_row === IDX_W'(p_row), p_tag, "mem_wr_row", 64'(mem_wr_row), 64'(p_row));
            chk(mem_wr_data === p_rowdata, p_tag, "mem_wr_data", mem_wr_data, p_rowdata);
        end
    endtask

    // One clock: check the previous request, then present a new one.
    task automatic issue(input bit v, input bit st, input int addr, input int sz,
                         input bit sw, input logic [63:0] d, input string tag);
        int w;
        bit mis;
        logic [63:0] val;
        @(negedge clk);
        check_pending();
        w   = 1 << sz;
        mis = (addr % w) != 0;
        req_valid = v; req_store = st; req_addr = ADDR_W'(addr);
        req_size = 2'(sz); req_swap = sw; req_wdata = d;
        p_rv = v && !st; p_err = v && mis; p_we = v && st && !mis;
        p_data = '0; p_tag = v ? tag : "R9";
        p_row = addr / ROW_BYTES;
        if (v && !mis) begin
            if (st) begin
                for (int i = 0; i < w; i++)
                    ref_mem[addr+i] = sw ? d[(w-1-i)*8 +: 8] : d[i*8 +: 8];
                for (int i = 0; i < ROW_BYTES; i++)
                    p_rowdata[i*8 +: 8] = ref_mem[p_row*ROW_BYTES+i];
            end else begin
                val = '0;
                for (int i = 0; i < w; i++) begin
                    if (sw) val[(w-1-i)*8 +: 8] = ref_mem[addr+i];
                    else    val[i*8 +: 8]       = ref_mem[addr+i];
                end
                p_data = val;
            end
            #1;
            chk(mem_rd_en === 1'b1, "R1", "mem_rd_en", 64'(mem_rd_en), 64'd1);
            chk(mem_rd_row === IDX_W'(p_row), "R1", "mem_rd_row", 64'(mem_rd_row), 64'(p_row));
        end
    endtask

    task automatic idle();
        issue(1'b0, 1'b0, 0, 0, 1'b0, '0, "R9");
    endtask

    initial begin
        // R9: reset holds outputs quiet even with a store presented.
        req_valid = 1'b1; req_store = 1'b1; req_wdata = '1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b0, "R9", "rsp_valid in reset", 64'(rsp_valid), 0);
            chk(rsp_err === 1'b0, "R9", "rsp_err in reset", 64'(rsp_err), 0);
            chk(mem_wr_en === 1'b0, "R9", "mem_wr_en in reset", 64'(mem_wr_en), 0);
        end
        rst_n = 1'b1; req_valid = 1'b0;
        p_rv = 0; p_err = 0; p_we = 0;
        idle();

        // R2: unwritten rows read zero.
        issue(1, 0, 16'h40, 3, 0, '0, "R2");
        // R7: full-row store and load.
        issue(1, 1, 16'h10, 3, 0, 64'h8877665544332211, "R7");
        idle();
        issue(1, 0, 16'h10, 3, 0, '0, "R7");
        // R2: narrow loads at several offsets.
        issue(1, 0, 16'h13, 0, 0, '0, "R2");
        issue(1, 0, 16'h16, 1, 0, '0, "R2");
        issue(1, 0, 16'h14, 2, 0, '0, "R2");
        // R4: narrow stores, upper data bits ignored.
        issue(1, 1, 16'h21, 0, 0, 64'hFFFF_FFFF_FFFF_FFA5, "R4");
        issue(1, 1, 16'h2C, 2, 0, 64'hDEAD_BEEF_0BAD_F00D, "R4");
        issue(1, 1, 16'h22, 1, 0, 64'h1234_5678_9ABC_C3D4, "R4");
        idle();
        issue(1, 0, 16'h20, 3, 0, '0, "R4");
        // R3: swapped loads.
        issue(1, 0, 16'h10, 3, 1, '0, "R3");
        issue(1, 0, 16'h12, 1, 1, '0, "R3");
        issue(1, 0, 16'h14, 2, 1, '0, "R3");
        issue(1, 0, 16'h15, 0, 1, '0, "R3");
        // R5: swapped stores, then plain read-back.
        issue(1, 1, 16'h34, 2, 1, 64'hAABB_CCDD, "R5");
        issue(1, 1, 16'h30, 1, 1, 64'h0102, "R5");
        idle();
        issue(1, 0, 16'h30, 3, 0, '0, "R5");
        // R6: misaligned loads and stores, then confirm rows unchanged.
        issue(1, 0, 16'h11, 1, 0, '0, "R6");
        issue(1, 1, 16'h12, 2, 0, 64'hFFFF_FFFF, "R6");
        issue(1, 1, 16'h14, 3, 0, '1, "R6");
        issue(1, 0, 16'h16, 2, 1, '0, "R6");
        idle();
        issue(1, 0, 16'h10, 3, 0, '0, "R6");
        // R8: back-to-back same-row store/store/load and store/load.
        issue(1, 1, 16'h48, 0, 0, 64'h11, "R8");
        issue(1, 1, 16'h4A, 1, 0, 64'h3322, "R8");
        issue(1, 0, 16'h48, 3, 0, '0, "R8");
        issue(1, 1, 16'h4C, 2, 1, 64'h4455_6677, "R8");
        issue(1, 0, 16'h4C, 2, 0, '0, "R8");

        // Random traffic over eight rows, mixing every feature.
        for (int k = 0; k < 1500; k++) begin
            int sz, a;
            bit st, sw;
            sz = $urandom_range(3, 0);
            a  = $urandom_range(63, 0);
            if ($urandom_range(7, 0) != 0) a = a & ~((1 << sz) - 1);
            st = $urandom_range(1, 0);
            sw = $urandom_range(1, 0);
            if ($urandom_range(9, 0) == 0) idle();
            else issue(1, st, a, sz, sw, {$urandom, $urandom}, st ? "R4" : "R2");
        end
        idle();
        idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule